// File: doc/BRIEF.md
# Buffer Descriptor List Walker

This block walks a list of buffer descriptors held in memory on behalf of one direction of a DMA engine. Software places a list base address and a layout choice on the configuration inputs and pulses `start`. The walker then reads each 16-byte descriptor as four 32-bit words, using bursts capped by a programmable maximum burst length. It hands the descriptor's buffer addresses and byte counts to a downstream data mover, and once the mover reports completion it moves on to the next descriptor.

Two list layouts are supported. In ring layout the descriptors sit back to back, each can name two data buffers, and a flag in the descriptor sends the walk back to the base address. In chain layout each descriptor names one buffer, and its fourth word is the address of the following descriptor. A descriptor that the DMA does not own parks the walker in a suspended state until a poll-demand pulse arrives. A stop request takes effect only between descriptors. A transmit and a receive channel each use their own instance, so each one starts and stops independently of the other.

Top module: `desc_walker`

## Requirements
- R1: After synchronous reset, `state_o` reads 0 and `rd_req_valid` and `desc_valid` are low. The state codes are 0 stopped, 1 fetching, 2 waiting on the mover, 3 advancing and 4 suspended.
- R2: A `start` pulse in the stopped state captures `cfg_base`, `cfg_chain` and `cfg_max_burst`, and the first descriptor fetch reads from the captured base. Changes to these inputs while the walk runs have no effect.
- R3: Each descriptor is read as four words. A request asks for min(max(cap,1), words still missing) words, where cap is the captured maximum burst length and 0 counts as 1. The request address is the descriptor address plus 4 times the number of words already read. A new request is issued only after all data words of the previous one have arrived, and an unaccepted request holds its address and length.
- R4: The descriptor layout is as follows. Word 0 holds the DMA-owns flag in bit 31 and the end-of-ring flag in bit 30. Word 1 holds the first buffer byte count in bits 12:0 and the second in bits 28:16. Word 2 holds the first buffer address and word 3 holds the second buffer address or the link. An owned descriptor is shown with `desc_valid` high, and the outputs stay unchanged until `mover_done`.
- R5: In ring layout the next descriptor is at the current address plus 16. When the current descriptor carries the end-of-ring flag, the next one is at the captured base address instead.
- R6: In chain layout the next descriptor address is word 3 of the current one, and the end-of-ring flag is ignored. The second buffer outputs read zero.
- R7: A fetched descriptor without the DMA-owns flag puts the walker in the suspended state, with no read requests and `desc_valid` low. A `poll` pulse there fetches the same descriptor again.
- R8: A stop request during a fetch or while waiting on the mover lets the current descriptor complete, including its hand-off. The walker then goes to stopped instead of fetching the next one. A stop request while suspended stops the walker on the next clock.
- R9: A `start` pulse while the walker is not stopped is ignored, and the walk continues from its current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, used only when stopped |
| stop_req | input | 1 | Stop request pulse, honoured between descriptors |
| poll | input | 1 | Poll-demand pulse, used only when suspended |
| cfg_base | input | 32 | List base address |
| cfg_chain | input | 1 | Layout select: 1 chain, 0 ring |
| cfg_max_burst | input | BURST_W | Maximum burst length in words (0 acts as 1) |
| rd_req_valid | output | 1 | Read burst request valid |
| rd_req_ready | input | 1 | Read burst request accepted |
| rd_req_addr | output | 32 | Byte address of the burst's first word |
| rd_req_len | output | 3 | Words in the burst (1 to 4) |
| rd_data_valid | input | 1 | Read data word valid, returned in order |
| rd_data | input | 32 | Read data word |
| desc_valid | output | 1 | Descriptor presented to the data mover |
| desc_addr | output | 32 | Address of the current descriptor |
| buf1_addr | output | 32 | First buffer address |
| buf1_len | output | 13 | First buffer byte count |
| buf2_addr | output | 32 | Second buffer address (zero in chain layout) |
| buf2_len | output | 13 | Second buffer byte count (zero in chain layout) |
| mover_done | input | 1 | Data mover finished the presented descriptor |
| state_o | output | 3 | Walker state code |

## Verification
A wrong word counter or pending-burst counter shows on the very next read request, as a length or address that breaks the burst rule. A wrong next-address choice shows one descriptor later, as a `desc_addr` that differs from the bench's walk of the same memory image. A mishandled ownership flag or stop request shows within a few cycles on `state_o`, or as read requests that should not be there. Every presented descriptor is compared field by field against the bench's memory image, so a word stored in the wrong slot appears at the hand-off of that same descriptor.

// File: rtl/dw_pkg.sv
package dw_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int DESC_BYTES = DESC_WORDS * (WORD_W / 8);
    localparam int CNT_W      = $clog2(DESC_WORDS + 1);
    localparam int LEN_W      = 13;
    localparam int OWN_POS    = 31;
    localparam int EOR_POS    = 30;
    localparam int LEN2_LSB   = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_STOPPED   = 3'd0,
        ST_FETCH     = 3'd1,
        ST_WAIT_DATA = 3'd2,
        ST_ADVANCE   = 3'd3,
        ST_SUSPENDED = 3'd4
    } walk_state_e;

    typedef struct packed {
        logic             own;
        logic             eor;
        logic [LEN_W-1:0] len1;
        logic [LEN_W-1:0] len2;
        word_t            ptr1;
        word_t            ptr2;
    } desc_t;

    function automatic desc_t unpack_desc(input word_t w0, input word_t w1,
                                          input word_t w2, input word_t w3);
        desc_t d;
        d.own  = w0[OWN_POS];
        d.eor  = w0[EOR_POS];
        d.len1 = w1[LEN_W-1:0];
        d.len2 = w1[LEN2_LSB +: LEN_W];
        d.ptr1 = w2;
        d.ptr2 = w3;
        return d;
    endfunction

endpackage

// File: rtl/dw_burst_sizer.sv
module dw_burst_sizer
    import dw_pkg::*;
#(
    parameter int BURST_W = 6
) (
    input  logic [BURST_W-1:0] max_burst,
    input  logic [CNT_W-1:0]   remaining,
    output logic [CNT_W-1:0]   burst_len
);

    logic [BURST_W-1:0] cap;
    logic [BURST_W-1:0] rem_ext;

    always_comb begin
        cap       = (max_burst == '0) ? BURST_W'(1) : max_burst;
        rem_ext   = BURST_W'(remaining);
        burst_len = (cap < rem_ext) ? cap[CNT_W-1:0] : remaining;
    end

endmodule

// File: rtl/dw_desc_fetch.sv
module dw_desc_fetch
    import dw_pkg::*;
#(
    parameter int BURST_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  word_t              desc_base,
    input  logic [BURST_W-1:0] max_burst,
    output logic               req_valid,
    input  logic               req_ready,
    output word_t              req_addr,
    output logic [CNT_W-1:0]   req_len,
    input  logic               data_valid,
    input  word_t              data,
    output logic               done,
    output desc_t              desc
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DESC_WORDS);

    logic [CNT_W-1:0] rcvd;
    logic [CNT_W-1:0] pending;
    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] burst_len;
    logic             accept;
    logic             take;
    word_t            words [DESC_WORDS];

    assign remaining = FULL - rcvd;

    dw_burst_sizer #(.BURST_W(BURST_W)) u_sizer (
        .max_burst (max_burst),
        .remaining (remaining),
        .burst_len (burst_len)
    );

    assign req_valid = active && (pending == '0) && (rcvd != FULL);
    assign req_addr  = desc_base + {{(WORD_W-CNT_W-2){1'b0}}, rcvd, 2'b00};
    assign req_len   = burst_len;
    assign accept    = req_valid && req_ready;
    assign take      = active && data_valid && (pending != '0);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            rcvd    <= '0;
            pending <= '0;
        end else begin
            if (accept) begin
                pending <= burst_len;
            end else if (take) begin
                pending <= pending - 1'b1;
            end
            if (take) begin
                rcvd <= rcvd + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < DESC_WORDS; i++) begin : g_word
        word_t word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (take && rcvd == CNT_W'(i)) begin
                word_q <= data;
            end
        end
        assign words[i] = word_q;
    end

    assign done = active && (rcvd == FULL);
    assign desc = unpack_desc(words[0], words[1], words[2], words[3]);

endmodule

// File: rtl/dw_next_ptr.sv
module dw_next_ptr
    import dw_pkg::*;
(
    input  logic  chain,
    input  logic  eor,
    input  word_t cur,
    input  word_t list_base,
    input  word_t link,
    output word_t next
);

    always_comb begin
        if (chain) begin
            next = link;
        end else if (eor) begin
            next = list_base;
        end else begin
            next = cur + WORD_W'(DESC_BYTES);
        end
    end

endmodule

// File: rtl/desc_walker.sv
module desc_walker
    import dw_pkg::*;
#(
    parameter int BURST_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               stop_req,
    input  logic               poll,
    input  logic [WORD_W-1:0]  cfg_base,
    input  logic               cfg_chain,
    input  logic [BURST_W-1:0] cfg_max_burst,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [WORD_W-1:0]  rd_req_addr,
    output logic [CNT_W-1:0]   rd_req_len,
    input  logic               rd_data_valid,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               desc_valid,
    output logic [WORD_W-1:0]  desc_addr,
    output logic [WORD_W-1:0]  buf1_addr,
    output logic [LEN_W-1:0]   buf1_len,
    output logic [WORD_W-1:0]  buf2_addr,
    output logic [LEN_W-1:0]   buf2_len,
    input  logic               mover_done,
    output logic [2:0]         state_o
);

    walk_state_e        st;
    word_t              base_q;
    word_t              cur_q;
    logic               chain_q;
    logic [BURST_W-1:0] mb_q;
    logic               stop_pend;
    logic               f_done;
    desc_t              f_desc;
    word_t              next_addr;
    logic               halt;

    dw_desc_fetch #(.BURST_W(BURST_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .active     (st == ST_FETCH),
        .desc_base  (cur_q),
        .max_burst  (mb_q),
        .req_valid  (rd_req_valid),
        .req_ready  (rd_req_ready),
        .req_addr   (rd_req_addr),
        .req_len    (rd_req_len),
        .data_valid (rd_data_valid),
        .data       (rd_data),
        .done       (f_done),
        .desc       (f_desc)
    );

    dw_next_ptr u_next (
        .chain     (chain_q),
        .eor       (f_desc.eor),
        .cur       (cur_q),
        .list_base (base_q),
        .link      (f_desc.ptr2),
        .next      (next_addr)
    );

    assign halt = stop_pend || stop_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_STOPPED;
            base_q    <= '0;
            cur_q     <= '0;
            chain_q   <= 1'b0;
            mb_q      <= '0;
            stop_pend <= 1'b0;
        end else begin
            case (st)
                ST_STOPPED: begin
                    stop_pend <= 1'b0;
                    if (start) begin
                        base_q  <= cfg_base;
                        cur_q   <= cfg_base;
                        chain_q <= cfg_chain;
                        mb_q    <= cfg_max_burst;
                        st      <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (stop_req) begin
                        stop_pend <= 1'b1;
                    end
                    if (f_done) begin
                        if (!f_desc.own) begin
                            st <= halt ? ST_STOPPED : ST_SUSPENDED;
                        end else begin
                            st <= ST_WAIT_DATA;
                        end
                    end
                end
                ST_WAIT_DATA: begin
                    if (stop_req) begin
                        stop_pend <= 1'b1;
                    end
                    if (mover_done) begin
                        st <= ST_ADVANCE;
                    end
                end
                ST_ADVANCE: begin
                    cur_q <= next_addr;
                    st    <= halt ? ST_STOPPED : ST_FETCH;
                end
                ST_SUSPENDED: begin
                    if (halt) begin
                        st <= ST_STOPPED;
                    end else if (poll) begin
                        st <= ST_FETCH;
                    end
                end
                default: st <= ST_STOPPED;
            endcase
        end
    end

    assign desc_valid = (st == ST_WAIT_DATA);
    assign desc_addr  = cur_q;
    assign buf1_addr  = f_desc.ptr1;
    assign buf1_len   = f_desc.len1;
    assign buf2_addr  = chain_q ? '0 : f_desc.ptr2;
    assign buf2_len   = chain_q ? '0 : f_desc.len2;
    assign state_o    = st;

endmodule

// File: rtl/dw_walker_chk.sv
module dw_walker_chk
    import dw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               stop_req,
    input logic               poll,
    input logic               chain_mode,
    input logic               rd_req_valid,
    input logic               rd_req_ready,
    input logic [WORD_W-1:0]  rd_req_addr,
    input logic [CNT_W-1:0]   rd_req_len,
    input logic               desc_valid,
    input logic [WORD_W-1:0]  desc_addr,
    input logic [WORD_W-1:0]  buf1_addr,
    input logic [LEN_W-1:0]   buf1_len,
    input logic [WORD_W-1:0]  buf2_addr,
    input logic [LEN_W-1:0]   buf2_len,
    input logic               mover_done,
    input logic [2:0]         state_o
);

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd0 |-> !rd_req_valid && !desc_valid); // R1

    AST_REQ_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> state_o == 3'd1); // R3

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> rd_req_len >= 3'd1 && rd_req_len <= 3'd4); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len)); // R3

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !mover_done |=> desc_valid && $stable(desc_addr) && $stable(buf1_addr)
            && $stable(buf1_len) && $stable(buf2_addr) && $stable(buf2_len)); // R4

    AST_CHAIN_NO_BUF2: assert property (@(posedge clk) disable iff (rst)
        desc_valid && chain_mode |-> buf2_addr == '0 && buf2_len == '0); // R6

    AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd4 |-> !rd_req_valid && !desc_valid); // R7

    AST_POLL_REFETCH: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd4 && poll && !stop_req |=> state_o == 3'd1 && $stable(desc_addr)); // R7

    AST_SUSP_STOP: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd4 && stop_req |=> state_o == 3'd0); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd2 && start && !mover_done |=> state_o == 3'd2 && $stable(desc_addr)); // R9

endmodule

bind desc_walker dw_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .stop_req     (stop_req),
    .poll         (poll),
    .chain_mode   (chain_q),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_req_len   (rd_req_len),
    .desc_valid   (desc_valid),
    .desc_addr    (desc_addr),
    .buf1_addr    (buf1_addr),
    .buf1_len     (buf1_len),
    .buf2_addr    (buf2_addr),
    .buf2_len     (buf2_len),
    .mover_done   (mover_done),
    .state_o      (state_o)
);

// File: tb/tb_desc_walker.sv
module tb_desc_walker;

    localparam int CLK_PERIOD = 10;
    localparam int BW         = 6;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          stop_req = 1'b0;
    logic          poll = 1'b0;
    logic [31:0]   cfg_base = '0;
    logic          cfg_chain = 1'b0;
    logic [BW-1:0] cfg_max_burst = '0;
    logic          rd_req_valid;
    logic          rd_req_ready = 1'b0;
    logic [31:0]   rd_req_addr;
    logic [2:0]    rd_req_len;
    logic          rd_data_valid = 1'b0;
    logic [31:0]   rd_data = '0;
    logic          desc_valid;
    logic [31:0]   desc_addr;
    logic [31:0]   buf1_addr;
    logic [12:0]   buf1_len;
    logic [31:0]   buf2_addr;
    logic [12:0]   buf2_len;
    logic          mover_done = 1'b0;
    logic [2:0]    state_o;

    desc_walker #(.BURST_W(BW)) dut (
        .clk, .rst, .start, .stop_req, .poll, .cfg_base, .cfg_chain, .cfg_max_burst,
        .rd_req_valid, .rd_req_ready, .rd_req_addr, .rd_req_len,
        .rd_data_valid, .rd_data, .desc_valid, .desc_addr,
        .buf1_addr, .buf1_len, .buf2_addr, .buf2_len, .mover_done, .state_o
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          bad = 0;
    int          cyc = 0;
    int          req_count = 0;
    int          off = 0;
    int          cur_mb = 1;
    logic [31:0] first_addr = '0;
    logic [31:0] mem [int unsigned];
    logic [31:0] dq [$];

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic int exp_len(input int mb, input int o);
        int m;
        m = (mb == 0) ? 1 : mb;
        return (m < 4 - o) ? m : 4 - o;
    endfunction

    function automatic logic [31:0] exp_next(input bit chain, input logic [31:0] base,
                                             input logic [31:0] a);
        if (chain) return rdm(a + 12);
        return rdm(a)[30] ? base : a + 32'd16;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: returns burst data in order, random gaps and random ready
    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
        if (dq.size() > 0 && ($urandom % 4) != 0) begin
            rd_data_valid = 1'b1;
            rd_data       = dq.pop_front();
        end else begin
            rd_data_valid = 1'b0;
            rd_data       = '0;
        end
        rd_req_ready = !rst && (($urandom % 3) != 0);
        if (!rst && rd_req_valid && rd_req_ready) begin
            req_count++;
            if (off == 0) first_addr = rd_req_addr;
            check("R3 burst address", rd_req_addr, first_addr + 32'(4 * off));
            check("R3 burst length", 32'(rd_req_len), 32'(exp_len(cur_mb, off)));
            for (int k = 0; k < int'(rd_req_len); k++)
                dq.push_back(rdm(rd_req_addr + 32'(4 * k)));
            off = off + int'(rd_req_len);
            if (off >= 4) off = 0;
        end
    end

    task automatic put_desc(input logic [31:0] a, input bit own, input bit eor,
                            input logic [12:0] l1, input logic [12:0] l2,
                            input logic [31:0] p1, input logic [31:0] p2);
        mem[a]      = {own, eor, 30'h0};
        mem[a + 4]  = {3'b000, l2, 3'b000, l1};
        mem[a + 8]  = p1;
        mem[a + 12] = p2;
    endtask

    task automatic start_walk(input logic [31:0] base, input bit chain, input int mb);
        @(negedge clk);
        cfg_base      = base;
        cfg_chain     = chain;
        cfg_max_burst = BW'(mb);
        cur_mb        = mb;
        start         = 1'b1;
        @(negedge clk);
        start         = 1'b0;
        // R2: later changes to the configuration must not matter
        cfg_chain     = ~chain;
        cfg_max_burst = BW'(mb + 1);
        cfg_base      = base + 32'h40;
    endtask

    task automatic expect_desc(input string tag, input logic [31:0] a, input bit chain,
                               input bit do_stop, input bit do_start);
        int hold;
        while (!desc_valid) @(negedge clk);
        check({tag, " descriptor address"}, desc_addr, a);
        check("R3 first burst address", first_addr, a);
        check("R4 buffer 1 address", buf1_addr, rdm(a + 8));
        check("R4 buffer 1 length", 32'(buf1_len), 32'(rdm(a + 4)[12:0]));
        if (chain) begin
            check("R6 buffer 2 address zero", buf2_addr, 32'h0);
            check("R6 buffer 2 length zero", 32'(buf2_len), 32'h0);
        end else begin
            check("R4 buffer 2 address", buf2_addr, rdm(a + 12));
            check("R4 buffer 2 length", 32'(buf2_len), 32'(rdm(a + 4)[28:16]));
        end
        hold = $urandom % 4;
        if (do_stop) begin
            stop_req = 1'b1;
            @(negedge clk);
            stop_req = 1'b0;
        end
        if (do_start) begin
            cfg_base = 32'h900;
            start    = 1'b1;
            @(negedge clk);
            start    = 1'b0;
        end
        repeat (hold) @(negedge clk);
        check("R4 descriptor held until done", 32'(desc_valid), 32'h1);
        check("R4 address held until done", desc_addr, a);
        mover_done = 1'b1;
        @(negedge clk);
        mover_done = 1'b0;
    endtask

    task automatic check_stopped(input string tag);
        int rc;
        repeat (3) @(negedge clk);
        check({tag, " stopped after boundary"}, 32'(state_o), 32'd0);
        rc = req_count;
        repeat (8) @(negedge clk);
        check({tag, " no requests once stopped"}, 32'(req_count), 32'(rc));
        check({tag, " still stopped"}, 32'(state_o), 32'd0);
    endtask

    task automatic wait_susp();
        while (state_o != 3'd4) @(negedge clk);
    endtask

    task automatic random_walk(input int t);
        bit          chain;
        int          n;
        int          mb;
        logic [31:0] base;
        logic [31:0] a;
        logic [31:0] slots [7];
        chain = t[0];
        n     = (t % 3 == 0) ? 4 : ((t % 3 == 1) ? 5 : 7);
        mb    = $urandom % 8;
        base  = 32'h10000 * 32'(t + 1);
        for (int i = 0; i < n; i++)
            slots[i] = chain ? base + 32'(32 * ((i * 3) % n)) : base + 32'(16 * i);
        for (int i = 0; i < n; i++)
            put_desc(slots[i], 1'b1, chain ? 1'($urandom % 2) : (i == n - 1),
                     13'($urandom), 13'($urandom), $urandom, chain ? slots[(i + 1) % n] : $urandom);
        start_walk(base, chain, mb);
        a = base;
        for (int i = 0; i < 2 * n; i++) begin
            expect_desc(chain ? "R6 random chain" : "R5 random ring", a, chain, i == 2 * n - 1, 1'b0);
            a = exp_next(chain, base, a);
        end
        check_stopped("R8 random");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset state", 32'(state_o), 32'd0);
        check("R1 no request in reset", 32'(rd_req_valid), 32'd0);
        check("R1 no descriptor in reset", 32'(desc_valid), 32'd0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", 32'(state_o), 32'd0);
        check("R1 no requests while idle", 32'(req_count), 32'd0);

        // ring layout, single-word bursts, wrap on end-of-ring
        put_desc(32'h100, 1, 0, 13'd64,   13'd128, 32'hA000_0000, 32'hB000_0000);
        put_desc(32'h110, 1, 0, 13'd1500, 13'd0,   32'hA000_1000, 32'hB000_1000);
        put_desc(32'h120, 1, 1, 13'd8191, 13'd8191, 32'hA000_2000, 32'hB000_2000);
        start_walk(32'h100, 1'b0, 1);
        expect_desc("R2 first at base", 32'h100, 0, 0, 0);
        expect_desc("R5 ring step", 32'h110, 0, 0, 0);
        expect_desc("R5 ring step", 32'h120, 0, 0, 0);
        expect_desc("R5 wrap to base", 32'h100, 0, 0, 0);
        expect_desc("R5 ring step", 32'h110, 0, 1, 0);
        check_stopped("R8 ring");

        // chain layout, three-word cap, start ignored while running
        put_desc(32'h400,  1, 0, 13'd10, 13'd99, 32'hC000_0000, 32'h2000);
        put_desc(32'h2000, 1, 1, 13'd20, 13'd99, 32'hC000_1000, 32'h380);
        put_desc(32'h380,  1, 0, 13'd30, 13'd99, 32'hC000_2000, 32'h400);
        start_walk(32'h400, 1'b1, 3);
        expect_desc("R6 chain first", 32'h400, 1, 0, 0);
        expect_desc("R6 chain link", 32'h2000, 1, 0, 1);
        expect_desc("R9 start ignored", 32'h380, 1, 0, 0);
        expect_desc("R6 chain loop", 32'h400, 1, 1, 0);
        check_stopped("R8 chain");

        // zero cap acts as one word
        put_desc(32'h800, 1, 1, 13'd7, 13'd9, 32'hD000_0000, 32'hE000_0000);
        start_walk(32'h800, 1'b0, 0);
        expect_desc("R5 single ring wrap", 32'h800, 0, 0, 0);
        expect_desc("R5 single ring wrap", 32'h800, 0, 1, 0);
        check_stopped("R8 single");

        // ownership: suspend, poll, then stop while suspended
        put_desc(32'h600, 1, 0, 13'd44, 13'd55, 32'hF000_0000, 32'hF100_0000);
        put_desc(32'h610, 0, 1, 13'd66, 13'd77, 32'hF000_1000, 32'hF100_1000);
        start_walk(32'h600, 1'b0, 8);
        expect_desc("R2 first at base", 32'h600, 0, 0, 0);
        wait_susp();
        check("R7 suspended no descriptor", 32'(desc_valid), 32'd0);
        begin
            int rc;
            rc = req_count;
            repeat (6) @(negedge clk);
            check("R7 no requests while suspended", 32'(req_count), 32'(rc));
            check("R7 stays suspended", 32'(state_o), 32'd4);
        end
        mem[32'h610] = {1'b1, 1'b1, 30'h0};
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        expect_desc("R7 refetch after poll", 32'h610, 0, 0, 0);
        mem[32'h610] = {1'b0, 1'b1, 30'h0};
        expect_desc("R5 wrap to base", 32'h600, 0, 0, 0);
        wait_susp();
        check("R7 suspended again", 32'(state_o), 32'd4);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check("R8 stop while suspended", 32'(state_o), 32'd0);

        for (int t = 0; t < 6; t++) random_walk(t);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule